// File: doc/BRIEF.md
# Blinking General-Purpose I/O Port

This block is a 32-line general-purpose I/O port. Software programs it through a small register interface. The interface has a write strobe, a byte address and a 32-bit data word, and its read data is combinational from the address. Each line has four configuration bits: its driven level, its direction, a blink enable and an input polarity. The pad side receives an output enable and an output value for every line.

A single free-running timebase produces one blink phase. It toggles every `BLINK_DIV` clock cycles. Every line whose blink bit is set has that phase XORed into its driven level, so all blinking lines change together.

Pin inputs pass through a two-flop synchroniser and are then XORed with the polarity bits. The result can be read back at its own address. It is also exported on a port, so that a separate interrupt block can use the polarity-adjusted lines.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones (every line an input) and the level, blink and polarity registers read zero. With every line an input, pad_oe is zero.
- R2: The level register at byte offset 0x00, the direction register at 0x04, the blink register at 0x08 and the polarity register at 0x0C each return the last value written to them. A write takes effect at the clock edge on which reg_wr is high.
- R3: A direction bit of 1 makes pad_oe low for that line, and a direction bit of 0 makes it high.
- R4: For a line whose blink bit is 0, pad_out equals that line's level bit.
- R5: For a line whose blink bit is 1, pad_out equals its level bit XOR a shared blink phase. The phase changes every `BLINK_DIV` cycles, and all blinking lines change in the same cycle.
- R6: The read-only register at offset 0x10 returns the synchronised pins XOR the polarity register. A change on pad_in becomes visible after two rising clock edges and not after one.
- R7: in_level always carries the same value that offset 0x10 reads.
- R8: A write to offset 0x10 or to any unmapped offset changes no register. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | LINES (32) | Write data |
| reg_rdata | output | LINES (32) | Read data for reg_addr (combinational) |
| pad_in | input | LINES (32) | Raw pin levels, asynchronous |
| pad_oe | output | LINES (32) | Per-line output driver enable |
| pad_out | output | LINES (32) | Per-line driven value |
| in_level | output | LINES (32) | Synchronised, polarity-adjusted input lines |

## Verification
The assertions check the following on every cycle:
- a write to a mapped register is captured from the write data;
- writes to the data-in offset leave every register untouched;
- the blink counter never leaves its range;
- the phase flips only at counter wrap;
- the synchroniser moves each sample one stage per clock.

Only the bench scenarios can show the following:
- the pad-level results of direction and blink settings;
- the measured blink half-period, and that all blinking lines move together;
- the two-edge input latency and the polarity inversion;
- zero reads from unmapped offsets.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int OFS_OUT   = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_BLINK = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_DIN   = 'h10;
endpackage

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
    parameter int BLINK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } tb_t;

    tb_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt == LAST) begin
            t_d.cnt = '0;
            t_d.ph  = ~t_q.ph;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign phase = t_q.ph;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LAST);

    // R5
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.ph != $past(t_q.ph)) |-> ($past(t_q.cnt) == LAST));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    typedef struct packed {
        logic [LINES-1:0] s1;
        logic [LINES-1:0] s2;
    } sy_t;

    sy_t s_d, s_q;

    always_comb begin
        s_d.s1 = raw;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign synced = s_q.s2;

    // R6
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.s2 == $past(s_q.s1)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int LINES     = 32,
    parameter int ADDR_W    = 8,
    parameter int BLINK_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_oe,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  in_level
);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);

    typedef struct packed {
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] blk;
        logic [LINES-1:0] pol;
    } cfg_t;

    cfg_t c_d, c_q;
    logic             blink_phase;
    logic [LINES-1:0] pins_sync;
    logic [LINES-1:0] din_val;

    gpio_blink_timer #(.BLINK_DIV(BLINK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    gpio_in_sync #(.LINES(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pins_sync)
    );

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            case (reg_addr)
                A_OUT:   c_d.lvl = reg_wdata;
                A_DIR:   c_d.dir = reg_wdata;
                A_BLINK: c_d.blk = reg_wdata;
                A_POL:   c_d.pol = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.lvl <= '0;
            c_q.dir <= '1;
            c_q.blk <= '0;
            c_q.pol <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign din_val  = pins_sync ^ c_q.pol;
    assign in_level = din_val;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign pad_oe[i]  = ~c_q.dir[i];
        assign pad_out[i] = c_q.lvl[i] ^ (c_q.blk[i] & blink_phase);
    end

    always_comb begin
        case (reg_addr)
            A_OUT:   reg_rdata = c_q.lvl;
            A_DIR:   reg_rdata = c_q.dir;
            A_BLINK: reg_rdata = c_q.blk;
            A_POL:   reg_rdata = c_q.pol;
            A_DIN:   reg_rdata = din_val;
            default: reg_rdata = '0;
        endcase
    end

    // R2
    lvl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OUT) |=> (c_q.lvl == $past(reg_wdata)));

    // R2
    pol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_POL) |=> (c_q.pol == $past(reg_wdata)));

    // R8
    din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIN) |=> $stable(c_q));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int DIV = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out, in_level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_port #(.LINES(32), .ADDR_W(8), .BLINK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .in_level(in_level)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 level", v, 32'h0);
        rd(8'h04, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R1 blink", v, 32'h0);
        rd(8'h0C, v); chk("R1 pol", v, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h00, 32'hDEAD_BEEF);
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'h0F0F_0F0F);
        wr(8'h04, 32'hA5A5_5A5A);
        rd(8'h00, v); chk("R2 level", v, 32'hDEAD_BEEF);
        rd(8'h04, v); chk("R2 dir", v, 32'hA5A5_5A5A);
        rd(8'h08, v); chk("R2 blink", v, 32'h1234_5678);
        rd(8'h0C, v); chk("R2 pol", v, 32'h0F0F_0F0F);
    endtask

    task automatic t_dir();
        wr(8'h04, 32'hFF00_FF00);
        @(negedge clk);
        chk("R3 oe", pad_oe, 32'h00FF_00FF);
        wr(8'h04, 32'h0000_0001);
        @(negedge clk);
        chk("R3 oe2", pad_oe, 32'hFFFF_FFFE);
    endtask

    task automatic t_out();
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h3C3C_C3C3);
        @(negedge clk);
        chk("R4 steady", pad_out, 32'h3C3C_C3C3);
        repeat (DIV) @(negedge clk);
        chk("R4 no blink", pad_out, 32'h3C3C_C3C3);
    endtask

    task automatic t_blink();
        logic [31:0] a, b;
        int n;
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0000_0030);
        wr(8'h08, 32'h0000_00F0);
        @(negedge clk);
        a = pad_out;
        total++;
        if (a !== 32'h0000_0030 && a !== 32'h0000_00C0) begin
            bad++;
            $display("FAIL R5 phase: actual=%h expected=%h or %h", a, 32'h30, 32'hC0);
        end
        while (pad_out === a) @(negedge clk);
        b = pad_out;
        chk("R5 toggle", b, a ^ 32'h0000_00F0);
        n = 0;
        while (pad_out === b && n < 4 * DIV) begin
            @(negedge clk);
            n++;
        end
        chk("R5 half period", n, DIV);
        chk("R5 back", pad_out, a);
    endtask

    task automatic t_input();
        logic [31:0] v;
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0000_FFFF);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        rd(8'h10, v); chk("R6 idle", v, 32'h0000_FFFF);
        @(negedge clk);
        pad_in = 32'hA5A5_1234;
        @(negedge clk);
        chk("R6 one edge", reg_rdata, 32'h0000_FFFF);
        @(negedge clk);
        chk("R6 two edges", reg_rdata, 32'hA5A5_EDCB);
        chk("R7 in_level", in_level, 32'hA5A5_EDCB);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(8'h10, 32'h1111_1111);
        wr(8'h14, 32'h2222_2222);
        wr(8'h02, 32'h3333_3333);
        rd(8'h00, v); chk("R8 level kept", v, 32'h0000_0030);
        rd(8'h04, v); chk("R8 dir kept", v, 32'h0);
        rd(8'h08, v); chk("R8 blink kept", v, 32'h0);
        rd(8'h0C, v); chk("R8 pol kept", v, 32'h0000_FFFF);
        rd(8'h10, v); chk("R8 din", v, 32'hA5A5_EDCB);
        rd(8'h14, v); chk("R8 unmapped", v, 32'h0);
        rd(8'hFC, v); chk("R8 unmapped hi", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_dir();
        t_out();
        t_blink();
        t_input();
        t_ignore();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule